// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Rates

This block holds four byte-wide alarm registers (seconds, minutes, hours, day of month) and compares them against the BCD time supplied by an external timekeeping counter. The comparison runs once for each seconds tick. When it succeeds, the block emits a one-cycle interrupt pulse. The most significant bit of each alarm register is a "don't care" flag. The pattern of these flags chooses how often the alarm recurs: monthly, daily, hourly, once a minute, or on every second.

Software writes the alarm registers through a small byte port. Each write is range-checked for its own field, and a value out of range is dropped. Reads return the stored byte exactly as written, including the flag bit. The calendar counter and any bus adaptation sit outside the block.

Top module: `tod_alarm`

## Requirements
- R1: After reset all four alarm registers read 0x00 and `alarm_irq` is low.
- R2: A write with `reg_wr_en` high stores `reg_wdata` into the register chosen by `reg_addr` (0 seconds, 1 minutes, 2 hours, 3 day of month). `reg_rdata` returns the stored byte for `reg_addr` in the same cycle, bit 7 included.
- R3: A seconds or minutes write is accepted only when bits 6:0 are a BCD value from 00 to 59, with the low digit 0 to 9.
- R4: An hours write is accepted only when bits 5:0 are BCD 00 to 23. A day write is accepted only when bits 5:0 are valid BCD and not zero.
- R5: A rejected write, or a cycle with no write, leaves every alarm register unchanged.
- R6: With no flag bit set, a tick fires the alarm only when seconds, minutes, hours and day all equal the current time.
- R7: With only the day flag set, a tick fires the alarm when seconds, minutes and hours match, whatever the day.
- R8: With the day and hours flags set and the others clear, a tick fires the alarm when seconds and minutes match.
- R9: With the day, hours and minutes flags set and the seconds flag clear, a tick fires the alarm when seconds match.
- R10: Every other flag pattern fires the alarm on every tick.
- R11: `alarm_irq` rises in the cycle after the clock edge at which a rising edge of `sec_tick` is sampled and lasts one cycle. A tick held high for several cycles gives at most one pulse.
- R12: A tick that arrives in the same cycle as an alarm write is judged against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the alarm registers |
| reg_addr | input | 2 | Register select: 0 sec, 1 min, 2 hour, 3 day |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored byte of the selected register |
| sec_tick | input | 1 | Seconds tick from the timekeeping counter |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
A register write and a seconds tick can land in the same clock cycle. The compare then has to use either the old or the new alarm value. The bench drives a write and a matching tick on the same edge: the old seconds value matches the current time and the new one does not. It expects a pulse on that tick and none on the next tick, which is judged against the new value.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC  = 2'd0,
        SEL_MIN  = 2'd1,
        SEL_HOUR = 2'd2,
        SEL_DATE = 2'd3
    } alm_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] date;
    } alm_regs_t;

    // BCD field check: low digit decimal and whole field at or below limit
    function automatic logic bcd_in_range(input logic [BYTE_W-1:0] v,
                                          input logic [BYTE_W-1:0] lim);
        return (v[3:0] <= 4'd9) && (v <= lim);
    endfunction
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  addr,
    input  logic [BYTE_W-1:0] wdata,
    output alm_regs_t         regs_o
);
    localparam logic [BYTE_W-1:0] SEC_MAX  = 8'h59;
    localparam logic [BYTE_W-1:0] HOUR_MAX = 8'h23;
    localparam logic [BYTE_W-1:0] DATE_MAX = 8'h39;

    typedef struct packed {
        alm_regs_t r;
    } st_t;

    st_t st_d, st_q;
    logic ok_sec, ok_hour, ok_date;

    always_comb begin
        ok_sec  = bcd_in_range({1'b0, wdata[6:0]}, SEC_MAX);
        ok_hour = bcd_in_range({2'b00, wdata[5:0]}, HOUR_MAX);
        ok_date = bcd_in_range({2'b00, wdata[5:0]}, DATE_MAX) && (wdata[5:0] != 6'd0);
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                SEL_SEC:  if (ok_sec)  st_d.r.sec  = wdata;
                SEL_MIN:  if (ok_sec)  st_d.r.min  = wdata;
                SEL_HOUR: if (ok_hour) st_d.r.hour = wdata;
                default:  if (ok_date) st_d.r.date = wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o = st_q.r;

    assert_sec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.r.sec[6:0] <= 7'h59) && (st_q.r.min[6:0] <= 7'h59));
    assert_hour_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.r.hour[5:0] <= 6'h23);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.r));
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  alm_regs_t         regs_i,
    input  logic [BYTE_W-1:0] sec_i,
    input  logic [BYTE_W-1:0] min_i,
    input  logic [BYTE_W-1:0] hour_i,
    input  logic [BYTE_W-1:0] date_i,
    output logic              irq_o
);
    localparam int MSB = BYTE_W - 1;

    typedef struct packed {
        logic tick;
        logic irq;
    } st_t;

    st_t st_d, st_q;
    logic hit_s, hit_m, hit_h, hit_d, fire, strobe;
    logic [3:0] flags;
    logic spare_unused;

    assign spare_unused = ^{regs_i.hour[6], regs_i.date[6]};

    always_comb begin
        hit_s  = ({1'b0, regs_i.sec[6:0]}   == sec_i);
        hit_m  = ({1'b0, regs_i.min[6:0]}   == min_i);
        hit_h  = ({2'b00, regs_i.hour[5:0]} == hour_i);
        hit_d  = ({2'b00, regs_i.date[5:0]} == date_i);
        flags  = {regs_i.date[MSB], regs_i.hour[MSB], regs_i.min[MSB], regs_i.sec[MSB]};
        unique case (flags)
            4'b0000: fire = hit_d && hit_h && hit_m && hit_s;
            4'b1000: fire = hit_h && hit_m && hit_s;
            4'b1100: fire = hit_m && hit_s;
            4'b1110: fire = hit_s;
            default: fire = 1'b1;
        endcase
        strobe     = tick_i && !st_q.tick;
        st_d.tick  = tick_i;
        st_d.irq   = strobe && fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    assert_pulse_from_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(tick_i));
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    assert_every_second_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tick_i) && regs_i.sec[MSB]) |=> irq_o);
    assert_full_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tick_i) && flags == 4'b0000 && hit_d && hit_h && hit_m && hit_s) |=> irq_o);
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sec_tick,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_date,
    output logic       alarm_irq
);
    alm_regs_t regs;

    tod_alarm_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .regs_o (regs)
    );

    tod_alarm_cmp u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sec_tick),
        .regs_i (regs),
        .sec_i  (cur_sec),
        .min_i  (cur_min),
        .hour_i (cur_hour),
        .date_i (cur_date),
        .irq_o  (alarm_irq)
    );

    always_comb begin
        unique case (reg_addr)
            SEL_SEC:  reg_rdata = regs.sec;
            SEL_MIN:  reg_rdata = regs.min;
            SEL_HOUR: reg_rdata = regs.hour;
            default:  reg_rdata = regs.date;
        endcase
    end

    assert_irq_low_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !alarm_irq);
endmodule

// File: tb/tod_alarm_tb_top.sv
module tod_alarm_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic sec_tick = 1'b0;
    logic [7:0] cur_sec = 8'd0, cur_min = 8'd0, cur_hour = 8'd0, cur_date = 8'h01;
    logic alarm_irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tod_alarm dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .alarm_irq(alarm_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, exp);
    endtask

    task automatic set_all(input logic [7:0] s, m, h, d);
        wr(2'd0, s); wr(2'd1, m); wr(2'd2, h); wr(2'd3, d);
    endtask

    task automatic now(input logic [7:0] s, m, h, d);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
    endtask

    // One tick pulse; irq sampled after the edge that registers it, then must drop (R11)
    task automatic tick(input string req, input logic exp);
        @(negedge clk);
        sec_tick = 1'b1;
        @(posedge clk); #1 chk(req, {7'd0, alarm_irq}, {7'd0, exp});
        @(negedge clk);
        sec_tick = 1'b0;
        @(posedge clk); #1 chk("R11 pulse width", {7'd0, alarm_irq}, 8'd0);
    endtask

    task automatic t_reset;
        rd_chk("R1 sec reset", 2'd0, 8'h00);
        rd_chk("R1 min reset", 2'd1, 8'h00);
        rd_chk("R1 hour reset", 2'd2, 8'h00);
        rd_chk("R1 date reset", 2'd3, 8'h00);
        chk("R1 irq reset", {7'd0, alarm_irq}, 8'd0);
    endtask

    task automatic t_write_read;
        set_all(8'h45, 8'h30, 8'h12, 8'h15);
        rd_chk("R2 sec", 2'd0, 8'h45);
        rd_chk("R2 min", 2'd1, 8'h30);
        rd_chk("R2 hour", 2'd2, 8'h12);
        rd_chk("R2 date", 2'd3, 8'h15);
        wr(2'd1, 8'hB1);
        rd_chk("R2 mask bit readback", 2'd1, 8'hB1);
        wr(2'd1, 8'h30);
    endtask

    task automatic t_validate;
        wr(2'd0, 8'h60); rd_chk("R3 sec 60 rejected", 2'd0, 8'h45);
        wr(2'd0, 8'h5A); rd_chk("R3 sec 5A rejected", 2'd0, 8'h45);
        wr(2'd1, 8'h7F); rd_chk("R3 min 7F rejected", 2'd1, 8'h30);
        wr(2'd0, 8'h59); rd_chk("R3 sec 59 accepted", 2'd0, 8'h59);
        wr(2'd2, 8'h24); rd_chk("R4 hour 24 rejected", 2'd2, 8'h12);
        wr(2'd2, 8'h1A); rd_chk("R4 hour 1A rejected", 2'd2, 8'h12);
        wr(2'd2, 8'h23); rd_chk("R4 hour 23 accepted", 2'd2, 8'h23);
        wr(2'd3, 8'h00); rd_chk("R4 date 00 rejected", 2'd3, 8'h15);
        wr(2'd3, 8'h80); rd_chk("R5 masked date 00 unchanged", 2'd3, 8'h15);
        rd_chk("R5 other regs untouched", 2'd1, 8'h30);
    endtask

    task automatic t_monthly;
        set_all(8'h45, 8'h30, 8'h12, 8'h15);
        now(8'h45, 8'h30, 8'h12, 8'h15); tick("R6 full match", 1'b1);
        now(8'h45, 8'h30, 8'h12, 8'h16); tick("R6 date differs", 1'b0);
        now(8'h44, 8'h30, 8'h12, 8'h15); tick("R6 sec differs", 1'b0);
    endtask

    task automatic t_daily;
        set_all(8'h45, 8'h30, 8'h12, 8'h95);
        now(8'h45, 8'h30, 8'h12, 8'h16); tick("R7 any day", 1'b1);
        now(8'h45, 8'h30, 8'h13, 8'h16); tick("R7 hour differs", 1'b0);
    endtask

    task automatic t_hourly;
        set_all(8'h45, 8'h30, 8'h92, 8'h95);
        now(8'h45, 8'h30, 8'h07, 8'h02); tick("R8 any hour", 1'b1);
        now(8'h45, 8'h31, 8'h07, 8'h02); tick("R8 min differs", 1'b0);
    endtask

    task automatic t_minutely;
        set_all(8'h45, 8'hB0, 8'h92, 8'h95);
        now(8'h45, 8'h00, 8'h07, 8'h02); tick("R9 any minute", 1'b1);
        now(8'h46, 8'h00, 8'h07, 8'h02); tick("R9 sec differs", 1'b0);
    endtask

    task automatic t_every;
        set_all(8'hC5, 8'hB0, 8'h92, 8'h95);
        now(8'h01, 8'h02, 8'h03, 8'h04); tick("R10 all masked tick 1", 1'b1);
        now(8'h02, 8'h02, 8'h03, 8'h04); tick("R10 all masked tick 2", 1'b1);
        set_all(8'hC5, 8'hB0, 8'h92, 8'h15);
        now(8'h09, 8'h09, 8'h09, 8'h01); tick("R10 day flag clear", 1'b1);
    endtask

    task automatic t_held_tick;
        @(negedge clk); sec_tick = 1'b1;
        @(posedge clk); #1 chk("R11 first cycle of held tick", {7'd0, alarm_irq}, 8'd1);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 chk("R11 no repeat while held", {7'd0, alarm_irq}, 8'd0);
        end
        @(negedge clk); sec_tick = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 chk("R11 no pulse without tick", {7'd0, alarm_irq}, 8'd0);
        end
    endtask

    task automatic t_same_cycle;
        set_all(8'h45, 8'h30, 8'h12, 8'h15);
        now(8'h45, 8'h30, 8'h12, 8'h15);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h10; sec_tick = 1'b1;
        @(posedge clk); #1 chk("R12 old value judged", {7'd0, alarm_irq}, 8'd1);
        @(negedge clk); reg_wr_en = 1'b0; sec_tick = 1'b0;
        rd_chk("R12 write landed", 2'd0, 8'h10);
        tick("R12 new value judged", 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_validate();
        t_monthly();
        t_daily();
        t_hourly();
        t_minutely();
        t_every();
        t_held_tick();
        t_same_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule